// File: doc/BRIEF.md
# Floating-Point NaN Classify and Quiet Unit

This block inspects one floating-point operand in half, single or double precision and tells whether it is a NaN, and if so whether that NaN is quiet or signaling. It also returns a quieted copy of the operand and a canonical default NaN for the selected format. Everything is combinational, so the results follow the inputs in the same cycle. A floating-point datapath uses it for operand screening, for NaN propagation and for building results.

Two run-time controls set how signaling NaNs are recognised. One sets the polarity of the top fraction bit that separates the two NaN kinds. The other switches signaling NaNs off, so that every NaN counts as quiet. A three-bit style code picks which canonical default NaN pattern is produced.

Top module: `nanq_unit`

## Requirements
- R1: An operand is a NaN exactly when its exponent field is all ones and its fraction field is nonzero. `nan_o` equals `qnan_o | snan_o`, and `qnan_o` and `snan_o` are never both 1. Operand bits above the sign bit of the selected format have no effect on the three flags.
- R2: An all-ones exponent with a zero fraction (infinity of either sign) is never reported as any kind of NaN, in every mode.
- R3: The kind of a NaN depends only on the top fraction bit. With `snan_pol_i`=0 a 1 there means quiet and a 0 means signaling. With `snan_pol_i`=1 the meanings swap.
- R4: While `no_snan_i`=1, `snan_o` is 0 and every NaN raises `qnan_o`.
- R5: Format codes on `fmt_i`: 0 = half (sign 15, exponent [14:10], fraction [9:0]); 1 = single (sign 31, exponent [30:23], fraction [22:0]); 2 = double (sign 63, exponent [62:52], fraction [51:0]); 3 behaves exactly as 2.
- R6: For a signaling NaN, `quiet_o` is the operand with one edit. Under polarity 0 the top fraction bit is set. Under polarity 1 the top fraction bit is cleared and the bit just below it is set. All other bits, including those above the format, are kept.
- R7: When `snan_o` is 0 (a quiet NaN, a non-NaN, or any operand while `no_snan_i`=1), `quiet_o` equals the 64-bit operand unchanged.
- R8: `dnan_o` always has an all-ones exponent, zero bits above the format's sign bit, and the following sign and fraction for each style code on `dstyle_i`: 0 = top fraction bit only, sign 0; 1 = all fraction bits, sign 0; 2 = top fraction bit only, sign 1; 3 = all fraction bits, sign 1.
- R9: Style 4 follows the polarity: under polarity 0 it gives the top fraction bit only, and under polarity 1 it gives every fraction bit except the top one, in both cases with sign 0. Styles 5, 6 and 7 give the same pattern as style 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_i | input | 2 | Format select (half, single, double, double) |
| operand_i | input | 64 | Operand, right-aligned |
| snan_pol_i | input | 1 | Value of the top fraction bit that marks a signaling NaN |
| no_snan_i | input | 1 | Treat every NaN as quiet |
| dstyle_i | input | 3 | Default NaN pattern style |
| nan_o | output | 1 | Operand is a NaN of any kind |
| qnan_o | output | 1 | Operand is a quiet NaN |
| snan_o | output | 1 | Operand is a signaling NaN |
| quiet_o | output | 64 | Quieted operand, or the operand unchanged |
| dnan_o | output | 64 | Default NaN for the selected format and style |

## Verification
The assertions check on every evaluation the properties that hold for all inputs. The two NaN flags never overlap and together make up the NaN flag. No signaling flag appears while signaling NaNs are switched off. Infinity is never flagged. A non-signaling operand passes through unchanged. A quieted value carries the non-signaling top fraction bit and the original exponent. A default NaN is always a NaN, and style 4 is always quiet. The exact bit patterns come only from the bench's scenarios: which fraction bit is edited under each polarity, where each format's fields sit, that format code 3 behaves as double, and the value produced for each style code. For these the bench sweeps every half-precision operand under all four mode combinations, and it runs structured and pseudo-random sweeps for single and double.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    localparam int OP_W    = 64;
    localparam int NUM_FMT = 3;
    localparam int STYLE_W = 3;
    localparam int FMT_W   = 2;

    typedef enum logic [FMT_W-1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_DBL_AL = 2'd3
    } fmt_e;

    typedef enum logic [STYLE_W-1:0] {
        DN_TOP_POS  = 3'd0,
        DN_FULL_POS = 3'd1,
        DN_TOP_NEG  = 3'd2,
        DN_FULL_NEG = 3'd3,
        DN_BY_POL   = 3'd4
    } dn_style_e;

    typedef struct packed {
        logic            is_nan;
        logic            is_qnan;
        logic            is_snan;
        logic [OP_W-1:0] quieted;
        logic [OP_W-1:0] dflt;
    } lane_res_t;

    function automatic int exp_width(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int frac_width(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int lane_of(input logic [FMT_W-1:0] f);
        case (fmt_e'(f))
            FMT_HALF:   return 0;
            FMT_SINGLE: return 1;
            default:    return 2;
        endcase
    endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify
    import nanq_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int VW = EW + FW
) (
    input  logic [VW-1:0] mag_i,
    input  logic          snan_pol_i,
    input  logic          no_snan_i,
    output logic          is_nan_o,
    output logic          is_qnan_o,
    output logic          is_snan_o
);

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_full;
    logic          frac_any;
    logic          sig_mark;

    always_comb begin
        exp_f     = mag_i[FW +: EW];
        frac_f    = mag_i[FW-1:0];
        exp_full  = &exp_f;
        frac_any  = |frac_f;
        sig_mark  = (frac_f[FW-1] == snan_pol_i);
        is_nan_o  = exp_full && frac_any;
        is_snan_o = is_nan_o && !no_snan_i && sig_mark;
        is_qnan_o = is_nan_o && !(sig_mark && !no_snan_i);
    end

endmodule

// File: rtl/nanq_shape.sv
module nanq_shape
    import nanq_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [OP_W-1:0]    operand_i,
    input  logic               snan_pol_i,
    input  logic               is_snan_i,
    input  logic [STYLE_W-1:0] dstyle_i,
    output logic [OP_W-1:0]    quieted_o,
    output logic [OP_W-1:0]    dflt_o
);

    localparam int SIGN_POS = EW + FW;

    logic [FW-1:0] top_only;
    logic [FW-1:0] all_set;
    logic [FW-1:0] below_top;
    logic [FW-1:0] dfrac;
    logic          dsign;

    always_comb begin
        top_only  = '0;
        top_only[FW-1] = 1'b1;
        all_set   = '1;
        below_top = all_set >> 1;

        quieted_o = operand_i;
        if (is_snan_i) begin
            if (snan_pol_i) begin
                quieted_o[FW-1] = 1'b0;
                quieted_o[FW-2] = 1'b1;
            end else begin
                quieted_o[FW-1] = 1'b1;
            end
        end

        case (dn_style_e'(dstyle_i))
            DN_FULL_POS: begin dfrac = all_set;  dsign = 1'b0; end
            DN_TOP_NEG:  begin dfrac = top_only; dsign = 1'b1; end
            DN_FULL_NEG: begin dfrac = all_set;  dsign = 1'b1; end
            DN_BY_POL:   begin dfrac = snan_pol_i ? below_top : top_only; dsign = 1'b0; end
            default:     begin dfrac = top_only; dsign = 1'b0; end
        endcase

        dflt_o = '0;
        dflt_o[FW +: EW]   = '1;
        dflt_o[FW-1:0]     = dfrac;
        dflt_o[SIGN_POS]   = dsign;
    end

    always_comb begin
        if (is_snan_i) begin
            AST_QUIET_TOP_BIT: assert (quieted_o[FW-1] != snan_pol_i); // R6
            AST_QUIET_KEEPS_EXP: assert (quieted_o[FW +: EW] == operand_i[FW +: EW]); // R6
        end
        AST_DFLT_IS_NAN: assert ((&dflt_o[FW +: EW]) && (|dflt_o[FW-1:0])); // R8
        if (dstyle_i == DN_BY_POL) begin
            AST_POLSTYLE_QUIET: assert (dflt_o[FW-1] != snan_pol_i); // R9
        end
    end

endmodule

// File: rtl/nanq_lane.sv
module nanq_lane
    import nanq_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [OP_W-1:0]    operand_i,
    input  logic               snan_pol_i,
    input  logic               no_snan_i,
    input  logic [STYLE_W-1:0] dstyle_i,
    output lane_res_t          res_o
);

    logic is_nan;
    logic is_qnan;
    logic is_snan;
    logic [OP_W-1:0] quieted;
    logic [OP_W-1:0] dflt;

    nanq_classify #(.EW(EW), .FW(FW)) u_cls (
        .mag_i      (operand_i[EW+FW-1:0]),
        .snan_pol_i (snan_pol_i),
        .no_snan_i  (no_snan_i),
        .is_nan_o   (is_nan),
        .is_qnan_o  (is_qnan),
        .is_snan_o  (is_snan)
    );

    nanq_shape #(.EW(EW), .FW(FW)) u_shp (
        .operand_i  (operand_i),
        .snan_pol_i (snan_pol_i),
        .is_snan_i  (is_snan),
        .dstyle_i   (dstyle_i),
        .quieted_o  (quieted),
        .dflt_o     (dflt)
    );

    always_comb begin
        res_o.is_nan  = is_nan;
        res_o.is_qnan = is_qnan;
        res_o.is_snan = is_snan;
        res_o.quieted = quieted;
        res_o.dflt    = dflt;
    end

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
    import nanq_pkg::*;
(
    input  logic [1:0]  fmt_i,
    input  logic [63:0] operand_i,
    input  logic        snan_pol_i,
    input  logic        no_snan_i,
    input  logic [2:0]  dstyle_i,
    output logic        nan_o,
    output logic        qnan_o,
    output logic        snan_o,
    output logic [63:0] quiet_o,
    output logic [63:0] dnan_o
);

    lane_res_t lane_res [NUM_FMT];
    lane_res_t pick;

    generate
        for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
            nanq_lane #(.EW(exp_width(g)), .FW(frac_width(g))) u_lane (
                .operand_i  (operand_i),
                .snan_pol_i (snan_pol_i),
                .no_snan_i  (no_snan_i),
                .dstyle_i   (dstyle_i),
                .res_o      (lane_res[g])
            );
        end
    endgenerate

    always_comb begin
        pick    = lane_res[lane_of(fmt_i)];
        nan_o   = pick.is_nan;
        qnan_o  = pick.is_qnan;
        snan_o  = pick.is_snan;
        quiet_o = pick.quieted;
        dnan_o  = pick.dflt;
    end

    logic is_inf;
    always_comb begin
        case (fmt_i)
            2'd0:    is_inf = (operand_i[14:0] == 15'h7C00);
            2'd1:    is_inf = (operand_i[30:0] == 31'h7F80_0000);
            default: is_inf = (operand_i[62:0] == 63'h7FF0_0000_0000_0000);
        endcase
    end

    always_comb begin
        AST_FLAGS_DISJOINT: assert (!(qnan_o && snan_o)); // R1
        AST_FLAGS_COVER: assert (nan_o == (qnan_o || snan_o)); // R1
        AST_INF_NOT_NAN: assert (!(is_inf && nan_o)); // R2
        if (no_snan_i) begin
            AST_NO_SNAN_OFF: assert (!snan_o); // R4
        end
        if (!snan_o) begin
            AST_PASS_UNCHANGED: assert (quiet_o == operand_i); // R7
        end
    end

endmodule

// File: tb/sim_nanq_unit.sv
module sim_nanq_unit;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]  fmt    = 2'd0;
    logic [63:0] op     = 64'd0;
    logic        pol    = 1'b0;
    logic        nosig  = 1'b0;
    logic [2:0]  style  = 3'd0;
    logic        nan_w, qnan_w, snan_w;
    logic [63:0] quiet_w, dnan_w;

    int checks = 0;
    int fails  = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    nanq_unit u0 (
        .fmt_i      (fmt),
        .operand_i  (op),
        .snan_pol_i (pol),
        .no_snan_i  (nosig),
        .dstyle_i   (style),
        .nan_o      (nan_w),
        .qnan_o     (qnan_w),
        .snan_o     (snan_w),
        .quiet_o    (quiet_w),
        .dnan_o     (dnan_w)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s fmt=%0d op=%h pol=%0d nosig=%0d style=%0d: actual %h expected %h",
                     tag, fmt, op, pol, nosig, style, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Expected values from the requirements: R5 field geometry, R1/R3/R4 flags,
    // R6/R7 quieting, R8/R9 default patterns.
    task automatic expect_all(output logic en, output logic eq, output logic es,
                              output logic [63:0] qv, output logic [63:0] dv);
        int ew, fw;
        logic [63:0] one, emask, fmask, expf, fr, dfr;
        logic msb, sgn;
        case (fmt)
            2'd0:    begin ew = 5;  fw = 10; end
            2'd1:    begin ew = 8;  fw = 23; end
            default: begin ew = 11; fw = 52; end
        endcase
        one   = 64'd1;
        emask = (one << ew) - 1;
        fmask = (one << fw) - 1;
        expf  = (op >> fw) & emask;
        fr    = op & fmask;
        msb   = fr[fw-1];
        en    = (expf == emask) && (fr != 0);
        es    = en && !nosig && (msb == pol);
        eq    = en && !es;
        qv    = op;
        if (es) begin
            if (pol) qv = (op & ~(one << (fw-1))) | (one << (fw-2));
            else     qv = op | (one << (fw-1));
        end
        sgn = 1'b0;
        case (style)
            3'd1:    dfr = fmask;
            3'd2:    begin dfr = one << (fw-1); sgn = 1'b1; end
            3'd3:    begin dfr = fmask; sgn = 1'b1; end
            3'd4:    dfr = pol ? (fmask >> 1) : (one << (fw-1));
            default: dfr = one << (fw-1);
        endcase
        dv = ({63'd0, sgn} << (ew+fw)) | (emask << fw) | dfr;
    endtask

    task automatic run_vec(input string tag);
        logic en, eq, es;
        logic [63:0] qv, dv;
        #1;
        expect_all(en, eq, es, qv, dv);
        chk({tag, " R1 nan"}, {63'd0, nan_w}, {63'd0, en});
        chk({tag, " R3 R4 kind"}, {62'd0, qnan_w, snan_w}, {62'd0, eq, es});
        chk({tag, " R6 R7 quiet"}, quiet_w, qv);
        #1;
    endtask

    task automatic sweep_modes(input string tag);
        for (int m = 0; m < 4; m++) begin
            pol   = m[0];
            nosig = m[1];
            run_vec(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Initial state with a zero operand: nothing flagged, value passes (R1 R7)
        #2;
        chk("R1 initial nan", {63'd0, nan_w}, 64'd0);
        chk("R7 initial pass", quiet_w, 64'd0);

        // Exhaustive half precision under all polarity / no-signal combos (R1 R3 R4 R6 R7)
        fmt = 2'd0;
        style = 3'd0;
        for (int v = 0; v < 65536; v++) begin
            op = {48'd0, v[15:0]};
            sweep_modes("R5 half");
        end

        // Upper bits outside the half format must not matter (R1 R7)
        for (int k = 0; k < 64; k++) begin
            rng = next_rand(rng);
            op  = {rng[63:16], 1'b0, 5'h1F, rng[9:0]};
            sweep_modes("R1 half upper bits");
        end

        // Infinities of every format and sign, in every mode (R2)
        for (int f = 0; f < 4; f++) begin
            fmt = f[1:0];
            for (int s = 0; s < 2; s++) begin
                case (f)
                    0:       op = {48'd0, s[0], 15'h7C00};
                    1:       op = {32'd0, s[0], 31'h7F80_0000};
                    default: op = {s[0], 63'h7FF0_0000_0000_0000};
                endcase
                for (int m = 0; m < 4; m++) begin
                    pol = m[0]; nosig = m[1];
                    #1;
                    chk("R2 infinity flagged", {63'd0, nan_w}, 64'd0);
                    chk("R2 infinity passes", quiet_w, op);
                    #1;
                end
            end
        end

        // Structured and pseudo-random single / double / alias-double sweeps (R5)
        for (int f = 1; f < 4; f++) begin
            fmt = f[1:0];
            for (int k = 0; k < 3000; k++) begin
                rng = next_rand(rng);
                op  = rng;
                case (k % 6)
                    0: if (f == 1) op[30:23] = 8'hFF; else op[62:52] = 11'h7FF;
                    1: begin
                        if (f == 1) begin op[30:23] = 8'hFF; op[21:0] = '0; end
                        else begin op[62:52] = 11'h7FF; op[50:0] = '0; end
                    end
                    2: begin
                        if (f == 1) begin op[30:23] = 8'hFF; op[22:0] = 23'd1; end
                        else begin op[62:52] = 11'h7FF; op[51:0] = 52'd1; end
                    end
                    3: if (f == 1) op[30:23] = 8'hFE; else op[62:52] = 11'h7FE;
                    4: begin
                        if (f == 1) begin op[30:23] = 8'hFF; op[22:0] = 23'h40_0000; end
                        else begin op[62:52] = 11'h7FF; op[51:0] = 52'h8_0000_0000_0000; end
                    end
                    default: ;
                endcase
                sweep_modes(f == 3 ? "R5 alias double" : "R5 wide");
            end
        end

        // Default NaN for every format, style and polarity (R8 R9)
        op = 64'd0;
        nosig = 1'b0;
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 2; p++) begin
                    logic en, eq, es;
                    logic [63:0] qv, dv;
                    fmt = f[1:0]; style = s[2:0]; pol = p[0];
                    #1;
                    expect_all(en, eq, es, qv, dv);
                    chk(s >= 4 ? "R9 default style" : "R8 default style", dnan_w, dv);
                    #1;
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule